// File: doc/BRIEF.md
# Two-bank interrupt collector

This block gathers sixty-four interrupt request lines into one request wire for a single processor. The lines are split into two banks of thirty-two. Each bank keeps four pieces of state:

- a latch of captured events;
- an enable mask;
- the live level of its lines;
- a fixed, per-bit choice between edge and level behaviour.

Software works through a small 32-bit register bus decoded in a 4 KB window. Through it, software reads the captured events, the mask and the live levels, writes the mask, and clears captured events with an acknowledge write.

An edge-type line latches an event when the line rises. The event stays latched until software acknowledges it. A level-type line never latches an event. It raises the request for as long as it is high and enabled, and an acknowledge has no effect on it. Line numbering runs in reverse across the banks: the low thirty-two lines land in the second bank.

Top module: `irq_agg_ctrl`

## Requirements
- R1: Bank registers are found at byte offset 0x10 (bank 0) and 0x20 (bank 1). Any address whose value (addr - 0x10) >> 4 is not 0 or 1 reads as zero and ignores writes; this includes 0x004 and 0x034.
- R2: Within a bank, the register offsets are:
  - 0x4: mask, read and write.
  - 0x0: captured events, read only.
  - 0xC: live levels, read only.
  - 0x8: acknowledge, write only; it reads as zero.

  Writes to the read-only offsets change nothing.
- R3: Input line n belongs to bank 1 - (n >> 5), at bit n & 31. Lines 0-31 therefore appear in bank 1 and lines 32-63 in bank 0.
- R4: For an edge-type bit, a rising input sets the event bit on the next clock. The event bit stays set after the input falls, until it is acknowledged.
- R5: An acknowledge write clears each edge-type event bit whose data bit is 1 and leaves the others unchanged. If a rising edge arrives in the same cycle as the acknowledge, the set wins.
- R6: A level-type bit never sets its event bit. Its contribution to the request follows the live level. An acknowledge has no effect on it.
- R7: `cpu_irq` is the registered OR, across both banks, of (events | (levels & level_type)) & mask. It changes one clock after the state that causes it, including a mask write.
- R8: After reset, events, masks and levels are zero and `cpu_irq` is low. The level-type configuration is 0x00000000 for bank 0 and 0x1FF00000 for bank 1, which makes bits 20-28 of bank 1 level-type.
- R9: A read request returns its data with `bus_rvalid` high on the following cycle. `bus_rvalid` is low after a write or an idle cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_in | input | 64 | Interrupt lines, already synchronous to clk |
| bus_valid | input | 1 | Access request this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte address, word aligned |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read data valid, one cycle after a read |
| cpu_irq | output | 1 | Interrupt request to the processor |

## Verification
The hardest case to reach from the ports is an acknowledge write that lands in the same clock as a fresh rising edge on the bit it clears. The stimulus sets up this collision by changing the input line and issuing the acknowledge in the same low clock phase, so that one edge samples both. The bench then reads the event register to confirm that the set won. Level-type immunity is also hard to see, because those bits never show in the event register. It is exposed through `cpu_irq`, which is watched while a level-type line stays high through an acknowledge and then drops.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;

   // Byte offsets of the registers inside one bank slot (16-byte stride)
   localparam int unsigned SLOT_LOG2 = 4;
   localparam logic [3:0] OFS_EVT  = 4'h0;
   localparam logic [3:0] OFS_MASK = 4'h4;
   localparam logic [3:0] OFS_ACK  = 4'h8;
   localparam logic [3:0] OFS_LVL  = 4'hC;

   typedef enum logic [2:0] {
      SEL_EVT,
      SEL_MASK,
      SEL_ACK,
      SEL_LVL,
      SEL_NONE
   } reg_sel_e;

   function automatic reg_sel_e decode_ofs(input logic [3:0] ofs);
      case (ofs)
         OFS_EVT:  return SEL_EVT;
         OFS_MASK: return SEL_MASK;
         OFS_ACK:  return SEL_ACK;
         OFS_LVL:  return SEL_LVL;
         default:  return SEL_NONE;
      endcase
   endfunction

endpackage

// File: rtl/irq_agg_bank.sv
module irq_agg_bank #(
   parameter int unsigned W = 32,
   parameter logic [W-1:0] LT_INIT = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] in_lvl,
   input  logic         mask_we,
   input  logic         ack_we,
   input  logic [W-1:0] wdata,
   output logic [W-1:0] evt_o,
   output logic [W-1:0] mask_o,
   output logic [W-1:0] lvl_o,
   output logic [W-1:0] pend_o
);

   logic [W-1:0] evt_q, mask_q, lvl_q;
   logic [W-1:0] rise, edge_set, ack_clr, evt_d;

   always_comb begin
      rise     = in_lvl & ~lvl_q;
      edge_set = rise & ~LT_INIT;
      ack_clr  = ack_we ? (wdata & ~LT_INIT) : '0;
      evt_d    = (evt_q & ~ack_clr) | edge_set;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         evt_q  <= '0;
         mask_q <= '0;
         lvl_q  <= '0;
      end else begin
         evt_q <= evt_d;
         lvl_q <= in_lvl;
         if (mask_we) mask_q <= wdata;
      end
   end

   assign evt_o  = evt_q;
   assign mask_o = mask_q;
   assign lvl_o  = lvl_q;
   assign pend_o = (evt_q | (lvl_q & LT_INIT)) & mask_q;

   assert_lt_no_event_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (evt_q & LT_INIT) == '0);

   assert_event_holds_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !ack_we |=> ((evt_q & $past(evt_q)) == $past(evt_q)));

   assert_ack_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_we && ((rise & wdata) == '0)) |=> ((evt_q & $past(wdata)) == '0));

endmodule

// File: rtl/irq_agg_regif.sv
module irq_agg_regif
   import irq_agg_pkg::*;
#(
   parameter int unsigned W         = 32,
   parameter int unsigned NUM_BANKS = 2,
   parameter int unsigned ADDR_W    = 12,
   parameter int unsigned BASE      = 'h10
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   bus_valid,
   input  logic                   bus_we,
   input  logic [ADDR_W-1:0]      bus_addr,
   input  logic [W-1:0]           evt_i,
   input  logic [NUM_BANKS*W-1:0] evt_all,
   input  logic [NUM_BANKS*W-1:0] mask_all,
   input  logic [NUM_BANKS*W-1:0] lvl_all,
   output logic [NUM_BANKS-1:0]   mask_we,
   output logic [NUM_BANKS-1:0]   ack_we,
   output logic [W-1:0]           rdata,
   output logic                   rvalid
);

   localparam int unsigned IDX_W = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1;

   logic [ADDR_W-1:0] idx_full;
   logic [IDX_W-1:0]  sel_bank;
   logic              hit;
   reg_sel_e          sel;
   logic [W-1:0]      rd_mux;
   logic [W-1:0]      rdata_q;
   logic              rvalid_q;

   always_comb begin
      idx_full = (bus_addr - ADDR_W'(BASE)) >> SLOT_LOG2;
      hit      = idx_full < ADDR_W'(NUM_BANKS);
      sel_bank = idx_full[IDX_W-1:0];
      sel      = decode_ofs(bus_addr[SLOT_LOG2-1:0]);
   end

   for (genvar b = 0; b < NUM_BANKS; b++) begin : g_we
      assign mask_we[b] = bus_valid && bus_we && hit
                          && (sel_bank == IDX_W'(b)) && (sel == SEL_MASK);
      assign ack_we[b]  = bus_valid && bus_we && hit
                          && (sel_bank == IDX_W'(b)) && (sel == SEL_ACK);
   end

   always_comb begin
      rd_mux = '0;
      if (hit) begin
         case (sel)
            SEL_EVT:  rd_mux = evt_all[sel_bank*W +: W];
            SEL_MASK: rd_mux = mask_all[sel_bank*W +: W];
            SEL_LVL:  rd_mux = lvl_all[sel_bank*W +: W];
            default:  rd_mux = '0;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rdata_q  <= '0;
         rvalid_q <= 1'b0;
      end else begin
         rvalid_q <= bus_valid && !bus_we;
         rdata_q  <= (bus_valid && !bus_we) ? rd_mux : '0;
      end
   end

   assign rdata  = rdata_q;
   assign rvalid = rvalid_q;

   assert_miss_reads_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_valid && !bus_we && !hit) |=> (rdata == '0));

   assert_single_target_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({mask_we, ack_we}));

   // evt_i is the first bank's event vector, kept as a separate tap for the read check
   assert_evt_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_valid && !bus_we && hit && sel == SEL_EVT && sel_bank == '0)
      |=> (rdata == $past(evt_i)));

endmodule

// File: rtl/irq_agg_ctrl.sv
module irq_agg_ctrl #(
   parameter int unsigned BANK_W    = 32,
   parameter int unsigned NUM_BANKS = 2,
   parameter int unsigned ADDR_W    = 12,
   parameter int unsigned BASE      = 'h10,
   parameter logic [NUM_BANKS*BANK_W-1:0] LT_RESET = {32'h1FF0_0000, 32'h0000_0000}
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic [NUM_BANKS*BANK_W-1:0]   irq_in,
   input  logic                          bus_valid,
   input  logic                          bus_we,
   input  logic [ADDR_W-1:0]             bus_addr,
   input  logic [BANK_W-1:0]             bus_wdata,
   output logic [BANK_W-1:0]             bus_rdata,
   output logic                          bus_rvalid,
   output logic                          cpu_irq
);

   localparam int unsigned NUM_IN = NUM_BANKS * BANK_W;

   if (BANK_W < 1 || BANK_W > 32) begin : g_chk_w
      $error("BANK_W must be 1..32");
   end
   if (NUM_BANKS < 1) begin : g_chk_n
      $error("NUM_BANKS must be at least 1");
   end
   if (ADDR_W < 6 || BASE + NUM_BANKS * 16 > (1 << ADDR_W)) begin : g_chk_a
      $error("register window does not fit ADDR_W");
   end

   logic [NUM_IN-1:0]    evt_all, mask_all, lvl_all, pend_all;
   logic [NUM_BANKS-1:0] mask_we, ack_we;
   logic                 cpu_irq_q;

   for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
      // reverse placement: the highest group of lines feeds bank 0
      localparam int unsigned SRC = (NUM_BANKS - 1 - b) * BANK_W;
      irq_agg_bank #(
         .W       (BANK_W),
         .LT_INIT (LT_RESET[b*BANK_W +: BANK_W])
      ) u_bank (
         .clk     (clk),
         .rst_n   (rst_n),
         .in_lvl  (irq_in[SRC +: BANK_W]),
         .mask_we (mask_we[b]),
         .ack_we  (ack_we[b]),
         .wdata   (bus_wdata),
         .evt_o   (evt_all[b*BANK_W +: BANK_W]),
         .mask_o  (mask_all[b*BANK_W +: BANK_W]),
         .lvl_o   (lvl_all[b*BANK_W +: BANK_W]),
         .pend_o  (pend_all[b*BANK_W +: BANK_W])
      );
   end

   irq_agg_regif #(
      .W         (BANK_W),
      .NUM_BANKS (NUM_BANKS),
      .ADDR_W    (ADDR_W),
      .BASE      (BASE)
   ) u_regif (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_valid (bus_valid),
      .bus_we    (bus_we),
      .bus_addr  (bus_addr),
      .evt_i     (evt_all[BANK_W-1:0]),
      .evt_all   (evt_all),
      .mask_all  (mask_all),
      .lvl_all   (lvl_all),
      .mask_we   (mask_we),
      .ack_we    (ack_we),
      .rdata     (bus_rdata),
      .rvalid    (bus_rvalid)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) cpu_irq_q <= 1'b0;
      else        cpu_irq_q <= |pend_all;
   end

   assign cpu_irq = cpu_irq_q;

   assert_irq_needs_mask_R7: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_irq |-> ($past(mask_all) != '0));

endmodule

// File: tb/irq_agg_ctrl_tb.sv
`timescale 1ns/1ps
module irq_agg_ctrl_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [63:0] irq_in = '0;
   logic        bus_valid = 1'b0;
   logic        bus_we = 1'b0;
   logic [11:0] bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        bus_rvalid;
   logic        cpu_irq;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   irq_agg_ctrl u_dut (
      .clk(clk), .rst_n(rst_n), .irq_in(irq_in),
      .bus_valid(bus_valid), .bus_we(bus_we), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .bus_rvalid(bus_rvalid), .cpu_irq(cpu_irq)
   );

   typedef struct packed {
      logic        we;
      logic [11:0] addr;
      logic [31:0] data;
   } op_t;

   // R1/R2 register-map table: reads compare against data
   localparam int NOPS = 16;
   localparam op_t OPS [NOPS] = '{
      '{1'b1, 12'h014, 32'hA5A5_0F0F},
      '{1'b0, 12'h014, 32'hA5A5_0F0F},
      '{1'b1, 12'h024, 32'h1234_5678},
      '{1'b0, 12'h024, 32'h1234_5678},
      '{1'b0, 12'h014, 32'hA5A5_0F0F},
      '{1'b1, 12'h034, 32'hFFFF_FFFF},
      '{1'b0, 12'h034, 32'h0000_0000},
      '{1'b0, 12'h004, 32'h0000_0000},
      '{1'b1, 12'h010, 32'hFFFF_FFFF},
      '{1'b0, 12'h010, 32'h0000_0000},
      '{1'b0, 12'h018, 32'h0000_0000},
      '{1'b1, 12'h01C, 32'hFFFF_FFFF},
      '{1'b0, 12'h01C, 32'h0000_0000},
      '{1'b1, 12'h014, 32'h0000_0000},
      '{1'b1, 12'h024, 32'h0000_0000},
      '{1'b0, 12'h024, 32'h0000_0000}
   };

   task automatic check(input bit ok, input string req, input logic [31:0] act,
                        input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [11:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_valid = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_valid = 1'b0; bus_we = 1'b0;
   endtask

   task automatic rd(input logic [11:0] a, output logic [31:0] d, output logic v);
      @(negedge clk);
      bus_valid = 1'b1; bus_we = 1'b0; bus_addr = a;
      @(negedge clk);
      d = bus_rdata; v = bus_rvalid;
      bus_valid = 1'b0;
   endtask

   task automatic rd_chk(input logic [11:0] a, input logic [31:0] exp, input string req);
      logic [31:0] d;
      logic v;
      rd(a, d, v);
      check(v === 1'b1, "R9 rvalid", {31'b0, v}, 32'h1);
      check(d === exp, req, d, exp);
   endtask

   task automatic irq_chk(input logic exp, input string req);
      check(cpu_irq === exp, req, {31'b0, cpu_irq}, {31'b0, exp});
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog expired");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [31:0] d;
      logic v;
      repeat (3) @(negedge clk);
      // R8 reset state
      check(cpu_irq === 1'b0, "R8 cpu_irq in reset", {31'b0, cpu_irq}, 0);
      check(bus_rvalid === 1'b0, "R8 rvalid in reset", {31'b0, bus_rvalid}, 0);
      rst_n = 1'b1;
      rd_chk(12'h014, 32'h0, "R8 mask0 reset");
      rd_chk(12'h020, 32'h0, "R8 events1 reset");
      rd_chk(12'h02C, 32'h0, "R8 level1 reset");

      // R1 R2 table walk
      for (int i = 0; i < NOPS; i++) begin
         if (OPS[i].we) begin
            wr(OPS[i].addr, OPS[i].data);
            check(bus_rvalid === 1'b0, "R9 rvalid after write", {31'b0, bus_rvalid}, 0);
         end else begin
            rd_chk(OPS[i].addr, OPS[i].data, "R1/R2 register map");
         end
      end

      // R3 line placement
      @(negedge clk); irq_in[35] = 1'b1; irq_in[5] = 1'b1;
      rd_chk(12'h01C, 32'h0000_0008, "R3 line 35 -> bank0 bit3");
      rd_chk(12'h02C, 32'h0000_0020, "R3 line 5 -> bank1 bit5");
      @(negedge clk); irq_in[35] = 1'b0; irq_in[5] = 1'b0;
      // rising edges latched as events; clear them
      wr(12'h018, 32'hFFFF_FFFF);
      wr(12'h028, 32'hFFFF_FFFF);
      rd_chk(12'h010, 32'h0, "R5 ack all bank0");

      // R4 edge latch persists after input falls
      @(negedge clk); irq_in[40] = 1'b1;
      @(negedge clk); irq_in[40] = 1'b0;
      @(negedge clk);
      rd_chk(12'h010, 32'h0000_0100, "R4 event held after fall");
      rd_chk(12'h01C, 32'h0, "R4 level cleared");
      irq_chk(1'b0, "R7 masked event no irq");
      wr(12'h014, 32'h0000_0100);
      @(negedge clk);
      irq_chk(1'b1, "R7 irq one cycle after mask write");

      // R5 acknowledge
      wr(12'h018, 32'h0000_0100);
      rd_chk(12'h010, 32'h0, "R5 ack clears event");
      irq_chk(1'b0, "R7 irq drops after ack");
      wr(12'h014, 32'h0);

      // R6 level-type line 20 (bank1 bit20)
      @(negedge clk); irq_in[20] = 1'b1;
      @(negedge clk);
      rd_chk(12'h020, 32'h0, "R6 level line sets no event");
      wr(12'h024, 32'h0010_0000);
      @(negedge clk);
      irq_chk(1'b1, "R6 level line raises irq");
      wr(12'h028, 32'h0010_0000);
      @(negedge clk);
      irq_chk(1'b1, "R6 ack has no effect on level line");
      irq_in[20] = 1'b0;
      @(negedge clk); @(negedge clk);
      irq_chk(1'b0, "R6 irq follows level low");
      wr(12'h024, 32'h0);

      // R5 partial ack
      @(negedge clk); irq_in[0] = 1'b1; irq_in[1] = 1'b1;
      @(negedge clk); irq_in[0] = 1'b0; irq_in[1] = 1'b0;
      wr(12'h028, 32'h0000_0001);
      rd_chk(12'h020, 32'h0000_0002, "R5 partial ack");

      // R5 set wins over same-cycle ack
      @(negedge clk);
      irq_in[2] = 1'b1;
      bus_valid = 1'b1; bus_we = 1'b1; bus_addr = 12'h028; bus_wdata = 32'h0000_0004;
      @(negedge clk);
      bus_valid = 1'b0; bus_we = 1'b0;
      rd_chk(12'h020, 32'h0000_0006, "R5 edge wins over ack");
      wr(12'h028, 32'hFFFF_FFFF);
      rd_chk(12'h020, 32'h0, "R5 held high line no re-latch");
      irq_in[2] = 1'b0;

      // R9 idle cycle
      @(negedge clk);
      check(bus_rvalid === 1'b0, "R9 rvalid idle", {31'b0, bus_rvalid}, 0);
      rd(12'h02C, d, v);
      check(v === 1'b1 && d === 32'h0, "R9 read after idle", d, 32'h0);

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule